// File: doc/BRIEF.md
# Video bank address mapper

This block forms the 16-bit shared-memory address for a video controller that itself only drives a 14-bit address. Two bank-select bits come from a peripheral output port. They are stored inverted, so the mapper complements them and places them on the top two address bits. That selects one of four 16 KiB windows for the controller.

The mapper also decides where each video read is served from. A character ROM overlay covers in-bank offsets 0x1000-0x1FFF, but only in the two banks whose port bit 0 is set. Those banks start at 0x0000 and 0x8000. The processor never sees this overlay; it changes only the data returned to the video controller. RAM and ROM are synchronous with a fixed read latency. The overlay decision therefore passes through a short pipeline so that it steers the data mux in the cycle the addressed data arrives.

Top module: `video_bank_mapper`

## Requirements
- R1: `ram_addr_o[15:14]` equals the bitwise complement of `bank_sel_i`. Port value 0 maps to 0xC000-0xFFFF, 1 to 0x8000-0xBFFF, 2 to 0x4000-0x7FFF and 3 to 0x0000-0x3FFF.
- R2: `ram_addr_o[13:0]` equals `vid_addr_i` in the same cycle.
- R3: `rom_addr_o` equals `vid_addr_i[11:0]` in the same cycle.
- R4: A read is an overlay hit when `vid_addr_i[13:12]` is 2'b01 and `bank_sel_i[0]` is 1, which covers absolute 0x1000-0x1FFF and 0x9000-0x9FFF. For a hit, `vid_rdata_o` carries `rom_rdata_i` READ_LAT clock edges later.
- R5: Every other read is served from RAM: `vid_rdata_o` carries `ram_rdata_i` READ_LAT edges later. This covers offsets 0x1000-0x1FFF in banks with port value 0 or 2, and all other offsets in every bank.
- R6: `bank_sel_i[1]` has no effect on the overlay decision. Port values 3 and 1 both produce a hit at offset 0x1000, and port values 2 and 0 both produce RAM data there.
- R7: While `rst_ni` is low, and after its release until the first clock edge, `vid_rdata_o` carries `ram_rdata_i`.
- R8: With READ_LAT = 2, a hit presented for one cycle selects ROM data exactly two edges later and for one cycle only.
- R9: The data mux is combinational on the read-data inputs: a change on `ram_rdata_i` or `rom_rdata_i` appears on `vid_rdata_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vid_addr_i | input | 14 | Address from the video controller |
| bank_sel_i | input | 2 | Bank bits from the peripheral port, stored inverted |
| ram_rdata_i | input | 8 | Read data from shared RAM |
| rom_rdata_i | input | 8 | Read data from character ROM |
| ram_addr_o | output | 16 | Full address to shared RAM |
| rom_addr_o | output | 12 | Address to character ROM |
| vid_rdata_o | output | 8 | Data returned to the video controller |

## Verification
The bench builds two copies that share their inputs. The first uses the default read latency of one edge. Against it the bench walks the vector table: every bank value, both edges of the overlay window, and the unaffected pages. The second copy uses a latency of two. A single-cycle hit between misses then shows that the select pulse arrives at the right edge and lasts exactly one cycle on each copy. The reset checks hold an overlay address during reset, so a select register that does not clear would show up at once.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  localparam int unsigned VADDR_W = 14;
  localparam int unsigned BANK_W  = 2;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ROM_AW  = 12;
  localparam int unsigned MEM_AW  = VADDR_W + BANK_W;
  localparam int unsigned PAGE_W  = VADDR_W - ROM_AW;
endpackage

// File: rtl/vbm_bank_enc.sv
module vbm_bank_enc
  import vbm_pkg::*;
(
  input  logic [VADDR_W-1:0] vid_addr_i,
  input  logic [BANK_W-1:0]  bank_sel_i,
  output logic [MEM_AW-1:0]  ram_addr_o,
  output logic [ROM_AW-1:0]  rom_addr_o
);
  // port holds the bank number inverted
  assign ram_addr_o = {~bank_sel_i, vid_addr_i};
  assign rom_addr_o = vid_addr_i[ROM_AW-1:0];
endmodule

// File: rtl/vbm_overlay_det.sv
module vbm_overlay_det
  import vbm_pkg::*;
#(
  parameter int unsigned READ_LAT = 1,
  parameter int unsigned OVL_PAGE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              bank_lo_i,
  output logic              rom_sel_o
);
  localparam logic [PAGE_W-1:0] PAGE_MATCH = PAGE_W'(OVL_PAGE);

  logic              hit;
  logic [READ_LAT-1:0] pipe_q;

  assign hit = (page_i == PAGE_MATCH) && bank_lo_i;

  // align decision with synchronous memory latency
  generate
    if (READ_LAT == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= hit;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[READ_LAT-2:0], hit};
      end
    end
  endgenerate

  assign rom_sel_o = pipe_q[READ_LAT-1];

  assert_reset_ram_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !rom_sel_o);
endmodule

// File: rtl/vbm_data_mux.sv
module vbm_data_mux
  import vbm_pkg::*;
(
  input  logic              rom_sel_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic [DATA_W-1:0] vid_rdata_o
);
  always_comb begin
    if (rom_sel_i) vid_rdata_o = rom_rdata_i;
    else           vid_rdata_o = ram_rdata_i;
  end
endmodule

// File: rtl/video_bank_mapper.sv
module video_bank_mapper
  import vbm_pkg::*;
#(
  parameter int unsigned READ_LAT = 1,
  parameter int unsigned OVL_PAGE = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [VADDR_W-1:0] vid_addr_i,
  input  logic [BANK_W-1:0]  bank_sel_i,
  input  logic [DATA_W-1:0]  ram_rdata_i,
  input  logic [DATA_W-1:0]  rom_rdata_i,
  output logic [MEM_AW-1:0]  ram_addr_o,
  output logic [ROM_AW-1:0]  rom_addr_o,
  output logic [DATA_W-1:0]  vid_rdata_o
);
  logic rom_sel;

  vbm_bank_enc u_enc (
    .vid_addr_i (vid_addr_i),
    .bank_sel_i (bank_sel_i),
    .ram_addr_o (ram_addr_o),
    .rom_addr_o (rom_addr_o)
  );

  vbm_overlay_det #(
    .READ_LAT (READ_LAT),
    .OVL_PAGE (OVL_PAGE)
  ) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .page_i    (vid_addr_i[VADDR_W-1:ROM_AW]),
    .bank_lo_i (bank_sel_i[0]),
    .rom_sel_o (rom_sel)
  );

  vbm_data_mux u_mux (
    .rom_sel_i   (rom_sel),
    .ram_rdata_i (ram_rdata_i),
    .rom_rdata_i (rom_rdata_i),
    .vid_rdata_o (vid_rdata_o)
  );

  assert_bank_inv_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_addr_o[MEM_AW-1] != bank_sel_i[1]) && (ram_addr_o[MEM_AW-2] != bank_sel_i[0]));
  assert_low_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_addr_o[VADDR_W-1:0] == vid_addr_i);
  assert_rom_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_addr_o == ram_addr_o[ROM_AW-1:0]);

  generate
    if (READ_LAT == 1) begin : g_chk
      assert_rom_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vid_addr_i[VADDR_W-1:ROM_AW] == PAGE_W'(OVL_PAGE) && bank_sel_i[0])
        |=> (vid_rdata_o == rom_rdata_i));
      assert_ram_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(vid_addr_i[VADDR_W-1:ROM_AW] == PAGE_W'(OVL_PAGE) && bank_sel_i[0])
        |=> (vid_rdata_o == ram_rdata_i));
    end
  endgenerate
endmodule

// File: tb/video_bank_mapper_bench.sv
module video_bank_mapper_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 11;

  // {vid_addr[13:0], bank_sel[1:0], exp ram_addr[15:0], exp rom hit}
  localparam logic [32:0] VEC [NVEC] = '{
    {14'h1000, 2'd3, 16'h1000, 1'b1},
    {14'h1FFF, 2'd3, 16'h1FFF, 1'b1},
    {14'h0FFF, 2'd3, 16'h0FFF, 1'b0},
    {14'h2000, 2'd3, 16'h2000, 1'b0},
    {14'h1000, 2'd1, 16'h9000, 1'b1},
    {14'h1ABC, 2'd1, 16'h9ABC, 1'b1},
    {14'h1000, 2'd2, 16'h5000, 1'b0},
    {14'h1000, 2'd0, 16'hD000, 1'b0},
    {14'h3FFF, 2'd0, 16'hFFFF, 1'b0},
    {14'h0000, 2'd2, 16'h4000, 1'b0},
    {14'h2800, 2'd1, 16'hA800, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] vid_addr_i = '0;
  logic [1:0]  bank_sel_i = 2'd3;
  logic [7:0]  ram_rdata_i = '0;
  logic [7:0]  rom_rdata_i = '0;
  logic [15:0] ram_addr_o, ram_addr_l2;
  logic [11:0] rom_addr_o, rom_addr_l2;
  logic [7:0]  vid_rdata_o, vid_rdata_l2;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  video_bank_mapper u_video_bank_mapper (
    .clk_i, .rst_ni, .vid_addr_i, .bank_sel_i, .ram_rdata_i, .rom_rdata_i,
    .ram_addr_o, .rom_addr_o, .vid_rdata_o
  );

  video_bank_mapper #(.READ_LAT(2)) u_lat2 (
    .clk_i, .rst_ni, .vid_addr_i, .bank_sel_i, .ram_rdata_i, .rom_rdata_i,
    .ram_addr_o (ram_addr_l2), .rom_addr_o (rom_addr_l2), .vid_rdata_o (vid_rdata_l2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R7: overlay address held in reset must still return RAM data
    vid_addr_i = 14'h1000; bank_sel_i = 2'd3;
    ram_rdata_i = 8'h11; rom_rdata_i = 8'h22;
    repeat (3) @(negedge clk_i);
    #1 check("R7 in reset", 32'(vid_rdata_o), 32'h11);
    rst_ni = 1'b1;
    #1 check("R7 after release", 32'(vid_rdata_o), 32'h11);
    check("R7 lat2 after release", 32'(vid_rdata_l2), 32'h11);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      vid_addr_i = VEC[i][32:19];
      bank_sel_i = VEC[i][18:17];
      #1;
      check("R1 bank bits", 32'(ram_addr_o[15:14]), 32'(VEC[i][16:15]));
      check("R2 addr", 32'(ram_addr_o), 32'(VEC[i][16:1]));
      check("R3 rom addr", 32'(rom_addr_o), 32'(VEC[i][30:19]));
      @(negedge clk_i);
      ram_rdata_i = 8'(i * 7 + 3);
      rom_rdata_i = ~ram_rdata_i;
      #1;
      if (VEC[i][0]) check("R4/R6 rom data", 32'(vid_rdata_o), 32'(rom_rdata_i));
      else           check("R5/R6 ram data", 32'(vid_rdata_o), 32'(ram_rdata_i));
    end

    // R9: data mux follows read data within the cycle
    @(negedge clk_i);
    vid_addr_i = 14'h1234; bank_sel_i = 2'd3;
    @(negedge clk_i);
    rom_rdata_i = 8'h5E; #1;
    check("R9 rom pass", 32'(vid_rdata_o), 32'h5E);
    rom_rdata_i = 8'hC3; #1;
    check("R9 rom follow", 32'(vid_rdata_o), 32'hC3);

    // R8: single-cycle hit, latency 1 vs 2
    ram_rdata_i = 8'hAA; rom_rdata_i = 8'h55;
    vid_addr_i = 14'h0000; bank_sel_i = 2'd3;
    @(negedge clk_i); @(negedge clk_i);
    vid_addr_i = 14'h1800;
    @(negedge clk_i);
    vid_addr_i = 14'h0000;
    #1;
    check("R8 lat1 hit", 32'(vid_rdata_o), 32'h55);
    check("R8 lat2 not yet", 32'(vid_rdata_l2), 32'hAA);
    @(negedge clk_i); #1;
    check("R8 lat1 back to ram", 32'(vid_rdata_o), 32'hAA);
    check("R8 lat2 hit", 32'(vid_rdata_l2), 32'h55);
    @(negedge clk_i); #1;
    check("R8 lat2 one cycle", 32'(vid_rdata_l2), 32'hAA);

    // R7: asynchronous reset clears a pending hit
    vid_addr_i = 14'h1000;
    @(negedge clk_i);
    rst_ni = 1'b0; #1;
    check("R7 async clear", 32'(vid_rdata_o), 32'hAA);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule